// File: doc/BRIEF.md
# Dual-Queue Conversion Command Table with Completion Tracking

This block stores the command list for a two-queue analog-to-digital sequencer and tracks how far each queue has progressed. Software loads the 64 command words through a 16-bit register port. The sequencer fetches them through a separate read port, and the data comes back one cycle after the index is presented. Each command word holds a channel number, a sample-time selection and a pause flag. The block only stores these words and never alters them.

Alongside the table, the block keeps three pointers. The live fetch pointer follows the sequencer's fetches. Each queue also has a completion pointer, which moves only when that queue's conversion result is written. A two-bit activity field records which queue is running. A stop request returns all of this tracking state to its idle values. A freeze request holds it exactly as it is.

The converter, the result memory and the trigger logic sit outside this block. A tagged result-write strobe, a tagged fetch strobe, a tagged queue-done strobe and the queue 2 start index stand in for them.

Top module: `conv_cmd_table`

## Requirements
- R1: Register addresses 0 to 63 select table entries. A write stores bits [9:0] of the write data. A read returns the stored bits in [9:0] and zeros in [15:10], so write data in [15:10] is ignored. The word layout is pause flag in [9], sample time in [8:7] and channel in [6:0].
- R2: When `fetch_vld` is high, `fetch_data` shows the addressed table entry after the next clock edge. Otherwise it holds its last value.
- R3: A register write and a fetch to the same entry in the same cycle return the old word on that fetch. The new word appears on later fetches.
- R4: A result write updates the completion pointer of the tagged queue (`res_q` 0 = queue 1, 1 = queue 2) to `res_idx` at the next edge. The other queue's pointer is unchanged. Fetches never move a completion pointer.
- R5: A read at address 64 returns the completion pointers. Queue 1 is in [13:8] and queue 2 is in [5:0]. Bits [15:14] and [7:6] read as zero.
- R6: Writes to addresses 64 and 65 have no effect on any pointer or on the activity field.
- R7: A queue 1 fetch whose index equals `q2_begin` sets the fetch pointer to that index and clears queue 1 activity. The queue 1 completion pointer keeps its previous value.
- R8: Reset, or `stop` at a clock edge, sets both completion pointers to 63, clears the activity field and sets the fetch pointer to 0. `stop` overrides a result write in the same cycle.
- R9: While `freeze` is high, the completion pointers, the activity field and the fetch pointer hold their values. Result writes and fetch strobes in that period have no effect on them.
- R10: Any other fetch sets the activity bit of its tagged queue and loads the fetch pointer. `done_vld` clears the activity bit of `done_q`. `q_active[0]` is queue 1 and `q_active[1]` is queue 2.
- R11: A read at address 65 returns queue 1 activity in [9], queue 2 activity in [8] and the fetch pointer in [5:0]. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 7 | Register word address |
| sw_wdata | input | 16 | Register write data |
| sw_rdata | output | 16 | Register read data (combinational) |
| fetch_vld | input | 1 | Command fetch strobe |
| fetch_q | input | 1 | Fetching queue (0 = queue 1) |
| fetch_idx | input | 6 | Entry to fetch |
| fetch_data | output | 10 | Fetched command word |
| q2_begin | input | 6 | Index of the first queue 2 command |
| res_vld | input | 1 | Conversion result written |
| res_q | input | 1 | Queue of the written result |
| res_idx | input | 6 | Command index of the written result |
| done_vld | input | 1 | Queue finished strobe |
| done_q | input | 1 | Queue that finished |
| stop | input | 1 | Stop mode request |
| freeze | input | 1 | Freeze request |
| cwp_q1 | output | 6 | Queue 1 last-completed pointer |
| cwp_q2 | output | 6 | Queue 2 last-completed pointer |
| q_active | output | 2 | Queue activity field |
| fetch_ptr | output | 6 | Live fetch pointer |

## Verification
The hardest situation to reach is freeze with strobes still arriving. The bench first builds a non-trivial state: queue 1 active, a fetch pointer that is neither 0 nor 63, and completion pointers that differ from their stop values. Only then does it raise freeze, together with a result write and a fetch from the other queue. If the held values moved, the change would show. The queue 2 start boundary is reached by fetching the `q2_begin` index from queue 1 after queue 1 has already recorded a completion. The same-cycle write and fetch of one entry is exercised on an entry that already holds a known word.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int TBL_DEPTH = 64;
    localparam int IDX_W     = $clog2(TBL_DEPTH);
    localparam int ADDR_W    = IDX_W + 1;
    localparam int REG_W     = 16;
    localparam int NUM_Q     = 2;

    typedef struct packed {
        logic       pause;
        logic [1:0] samp;
        logic [6:0] chan;
    } cmd_word_t;

    localparam int CMD_W = $bits(cmd_word_t);

    typedef enum logic {
        Q_ONE = 1'b0,
        Q_TWO = 1'b1
    } qsel_t;

    function automatic logic [REG_W-1:0] pack_ptrs(
        input logic [IDX_W-1:0] p1,
        input logic [IDX_W-1:0] p2
    );
        return {2'b00, p1, 2'b00, p2};
    endfunction

    function automatic logic [REG_W-1:0] pack_act(
        input logic [NUM_Q-1:0] act,
        input logic [IDX_W-1:0] fptr
    );
        return {6'b0, act[0], act[1], 2'b00, fptr};
    endfunction
endpackage

// File: rtl/cmdq_table.sv
module cmdq_table
    import cmdq_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    parameter int W     = CMD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_idx,
    output logic [W-1:0]  fetch_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Registered fetch: read-before-write on a same-cycle collision
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_data <= '0;
        end else if (fetch_vld) begin
            fetch_data <= mem[fetch_idx];
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cmdq_track.sv
module cmdq_track
    import cmdq_pkg::*;
#(
    parameter int AW = IDX_W,
    parameter int NQ = NUM_Q
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stop,
    input  logic          freeze,
    input  logic          fetch_vld,
    input  logic          fetch_q,
    input  logic [AW-1:0] fetch_idx,
    input  logic [AW-1:0] q2_begin,
    input  logic          res_vld,
    input  logic          res_q,
    input  logic [AW-1:0] res_idx,
    input  logic          done_vld,
    input  logic          done_q,
    output logic [AW-1:0] cwp [NQ],
    output logic [NQ-1:0] q_active,
    output logic [AW-1:0] fetch_ptr
);
    logic          clear;
    logic          advance;
    logic          q1_boundary;
    logic [NQ-1:0] act_nxt;

    assign clear   = rst || stop;
    assign advance = !freeze;
    assign q1_boundary = fetch_vld && (qsel_t'(fetch_q) == Q_ONE) && (fetch_idx == q2_begin);

    // Per-queue completion pointers, moved only by that queue's result write
    for (genvar g = 0; g < NQ; g++) begin : g_cwp
        always_ff @(posedge clk) begin
            if (clear) begin
                cwp[g] <= '1;
            end else if (advance && res_vld && (int'(res_q) == g)) begin
                cwp[g] <= res_idx;
            end
        end
    end

    always_comb begin
        act_nxt = q_active;
        if (q1_boundary) begin
            act_nxt[Q_ONE] = 1'b0;
        end else if (fetch_vld) begin
            act_nxt[fetch_q] = 1'b1;
        end
        if (done_vld) begin
            act_nxt[done_q] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            q_active  <= '0;
            fetch_ptr <= '0;
        end else if (advance) begin
            q_active <= act_nxt;
            if (fetch_vld) begin
                fetch_ptr <= fetch_idx;
            end
        end
    end
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int AW  = IDX_W,
    parameter int ADW = ADDR_W,
    parameter int W   = CMD_W,
    parameter int RW  = REG_W
) (
    input  logic           sw_wr,
    input  logic [ADW-1:0] sw_addr,
    input  logic [RW-1:0]  sw_wdata,
    input  logic [W-1:0]   tbl_word,
    input  logic [AW-1:0]  cwp_q1,
    input  logic [AW-1:0]  cwp_q2,
    input  logic [1:0]     q_active,
    input  logic [AW-1:0]  fetch_ptr,
    output logic           tbl_wr,
    output logic [AW-1:0]  tbl_idx,
    output logic [W-1:0]   tbl_wdata,
    output logic [RW-1:0]  sw_rdata
);
    localparam logic [ADW-1:0] STAT_ADDR = ADW'(1 << AW);
    localparam logic [ADW-1:0] ACT_ADDR  = STAT_ADDR + ADW'(1);

    logic tbl_hit;

    assign tbl_hit   = !sw_addr[ADW-1];
    assign tbl_idx   = sw_addr[AW-1:0];
    assign tbl_wr    = sw_wr && tbl_hit;
    assign tbl_wdata = sw_wdata[W-1:0];

    always_comb begin
        sw_rdata = '0;
        if (tbl_hit) begin
            sw_rdata[W-1:0] = tbl_word;
        end else if (sw_addr == STAT_ADDR) begin
            sw_rdata = pack_ptrs(cwp_q1, cwp_q2);
        end else if (sw_addr == ACT_ADDR) begin
            sw_rdata = pack_act(q_active, fetch_ptr);
        end
    end
endmodule

// File: rtl/conv_cmd_table.sv
module conv_cmd_table
    import cmdq_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int ADW  = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr,
    input  logic [ADW-1:0]    sw_addr,
    input  logic [REG_W-1:0]  sw_wdata,
    output logic [REG_W-1:0]  sw_rdata,
    input  logic              fetch_vld,
    input  logic              fetch_q,
    input  logic [AW-1:0]     fetch_idx,
    output logic [CMD_W-1:0]  fetch_data,
    input  logic [AW-1:0]     q2_begin,
    input  logic              res_vld,
    input  logic              res_q,
    input  logic [AW-1:0]     res_idx,
    input  logic              done_vld,
    input  logic              done_q,
    input  logic              stop,
    input  logic              freeze,
    output logic [AW-1:0]     cwp_q1,
    output logic [AW-1:0]     cwp_q2,
    output logic [NUM_Q-1:0]  q_active,
    output logic [AW-1:0]     fetch_ptr
);
    logic             tbl_wr;
    logic [AW-1:0]    tbl_idx;
    logic [CMD_W-1:0] tbl_wdata;
    logic [CMD_W-1:0] tbl_word;
    logic [AW-1:0]    cwp [NUM_Q];

    cmdq_regs #(.AW(AW), .ADW(ADW), .W(CMD_W), .RW(REG_W)) u_regs (
        .sw_wr     (sw_wr),
        .sw_addr   (sw_addr),
        .sw_wdata  (sw_wdata),
        .tbl_word  (tbl_word),
        .cwp_q1    (cwp_q1),
        .cwp_q2    (cwp_q2),
        .q_active  (q_active),
        .fetch_ptr (fetch_ptr),
        .tbl_wr    (tbl_wr),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .sw_rdata  (sw_rdata)
    );

    cmdq_table #(.DEPTH(DEPTH), .W(CMD_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tbl_wr),
        .wr_idx     (tbl_idx),
        .wr_data    (tbl_wdata),
        .rd_idx     (tbl_idx),
        .rd_data    (tbl_word),
        .fetch_vld  (fetch_vld),
        .fetch_idx  (fetch_idx),
        .fetch_data (fetch_data)
    );

    cmdq_track #(.AW(AW), .NQ(NUM_Q)) u_track (
        .clk       (clk),
        .rst       (rst),
        .stop      (stop),
        .freeze    (freeze),
        .fetch_vld (fetch_vld),
        .fetch_q   (fetch_q),
        .fetch_idx (fetch_idx),
        .q2_begin  (q2_begin),
        .res_vld   (res_vld),
        .res_q     (res_q),
        .res_idx   (res_idx),
        .done_vld  (done_vld),
        .done_q    (done_q),
        .cwp       (cwp),
        .q_active  (q_active),
        .fetch_ptr (fetch_ptr)
    );

    assign cwp_q1 = cwp[0];
    assign cwp_q2 = cwp[1];
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker
    import cmdq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sw_addr,
    input logic [REG_W-1:0]  sw_rdata,
    input logic              fetch_vld,
    input logic              fetch_q,
    input logic [IDX_W-1:0]  fetch_idx,
    input logic [IDX_W-1:0]  q2_begin,
    input logic              res_vld,
    input logic              res_q,
    input logic [IDX_W-1:0]  res_idx,
    input logic              done_vld,
    input logic              stop,
    input logic              freeze,
    input logic [IDX_W-1:0]  cwp_q1,
    input logic [IDX_W-1:0]  cwp_q2,
    input logic [NUM_Q-1:0]  q_active,
    input logic [IDX_W-1:0]  fetch_ptr
);
    // R1
    tbl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_addr[ADDR_W-1] |-> sw_rdata[15:10] == 6'b0);

    // R5
    stat_layout_chk: assert property (@(posedge clk) disable iff (rst)
        sw_addr == 7'd64 |-> (sw_rdata[15:14] == 2'b0 && sw_rdata[7:6] == 2'b0
                              && sw_rdata[13:8] == cwp_q1 && sw_rdata[5:0] == cwp_q2));

    // R4
    res_update_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !freeze && !stop) |=>
            (($past(res_q) ? cwp_q2 : cwp_q1) == $past(res_idx)));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> (cwp_q1 == 6'h3F && cwp_q2 == 6'h3F && q_active == 2'b00 && fetch_ptr == 6'h00));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !stop) |=> ($stable(cwp_q1) && $stable(cwp_q2)
                               && $stable(q_active) && $stable(fetch_ptr)));

    // R7
    q2_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !fetch_q && fetch_idx == q2_begin && !freeze && !stop
         && !res_vld && !done_vld) |=>
            (!q_active[0] && fetch_ptr == $past(fetch_idx) && $stable(cwp_q1)));
endmodule

bind conv_cmd_table cmdq_checker u_cmdq_checker (
    .clk       (clk),
    .rst       (rst),
    .sw_addr   (sw_addr),
    .sw_rdata  (sw_rdata),
    .fetch_vld (fetch_vld),
    .fetch_q   (fetch_q),
    .fetch_idx (fetch_idx),
    .q2_begin  (q2_begin),
    .res_vld   (res_vld),
    .res_q     (res_q),
    .res_idx   (res_idx),
    .done_vld  (done_vld),
    .stop      (stop),
    .freeze    (freeze),
    .cwp_q1    (cwp_q1),
    .cwp_q2    (cwp_q2),
    .q_active  (q_active),
    .fetch_ptr (fetch_ptr)
);

// File: tb/conv_cmd_table_bench.sv
`timescale 1ns/1ps
module conv_cmd_table_bench;
    localparam int SEL_FDATA = 0;
    localparam int SEL_CWP1  = 1;
    localparam int SEL_CWP2  = 2;
    localparam int SEL_ACT   = 3;
    localparam int SEL_FPTR  = 4;
    localparam int SEL_RDATA = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_wr = 1'b0;
    logic [6:0]  sw_addr = '0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic        fetch_vld = 1'b0;
    logic        fetch_q = 1'b0;
    logic [5:0]  fetch_idx = '0;
    logic [9:0]  fetch_data;
    logic [5:0]  q2_begin = 6'd40;
    logic        res_vld = 1'b0;
    logic        res_q = 1'b0;
    logic [5:0]  res_idx = '0;
    logic        done_vld = 1'b0;
    logic        done_q = 1'b0;
    logic        stop = 1'b0;
    logic        freeze = 1'b0;
    logic [5:0]  cwp_q1;
    logic [5:0]  cwp_q2;
    logic [1:0]  q_active;
    logic [5:0]  fetch_ptr;

    typedef struct {
        int          sel;
        logic [15:0] val;
        int          due;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   pcyc     = 0;
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    conv_cmd_table u_conv_cmd_table (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .fetch_vld(fetch_vld), .fetch_q(fetch_q),
        .fetch_idx(fetch_idx), .fetch_data(fetch_data), .q2_begin(q2_begin),
        .res_vld(res_vld), .res_q(res_q), .res_idx(res_idx), .done_vld(done_vld),
        .done_q(done_q), .stop(stop), .freeze(freeze), .cwp_q1(cwp_q1),
        .cwp_q2(cwp_q2), .q_active(q_active), .fetch_ptr(fetch_ptr)
    );

    always @(posedge clk) pcyc <= pcyc + 1;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            SEL_FDATA: return {6'b0, fetch_data};
            SEL_CWP1:  return {10'b0, cwp_q1};
            SEL_CWP2:  return {10'b0, cwp_q2};
            SEL_ACT:   return {14'b0, q_active};
            SEL_FPTR:  return {10'b0, fetch_ptr};
            default:   return sw_rdata;
        endcase
    endfunction

    // Monitor: pops expectations that fall due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == pcyc) begin
                logic [15:0] got;
                got = observe(sb[i].sel);
                checks++;
                if (got !== sb[i].val) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", sb[i].req,
                             sb[i].sel, got, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic want(int sel, logic [15:0] val, int off, string req);
        exp_t e;
        e.sel = sel; e.val = val; e.due = pcyc + off; e.req = req;
        sb.push_back(e);
    endtask

    task automatic adv();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_write(logic [6:0] a, logic [15:0] d);
        sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
        adv();
        sw_wr = 1'b0;
    endtask

    task automatic sw_read(logic [6:0] a, logic [15:0] e, string req);
        sw_addr = a;
        want(SEL_RDATA, e, 0, req);
        adv();
    endtask

    task automatic fetch_go(logic q, logic [5:0] idx);
        fetch_vld = 1'b1; fetch_q = q; fetch_idx = idx;
    endtask

    task automatic clr_strobes();
        fetch_vld = 1'b0; res_vld = 1'b0; done_vld = 1'b0; sw_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) adv();
        rst = 1'b0;
        // R8: reset values
        want(SEL_CWP1, 16'h003F, 0, "R8 reset cwp_q1");
        want(SEL_CWP2, 16'h003F, 0, "R8 reset cwp_q2");
        want(SEL_ACT,  16'h0000, 0, "R8 reset activity");
        want(SEL_FPTR, 16'h0000, 0, "R8 reset fetch_ptr");
        adv();

        // R1: upper bits dropped, table readback
        sw_write(7'd5, 16'hFFFF);
        sw_write(7'd6, 16'h0155);
        sw_write(7'd63, 16'hFEAA);
        sw_read(7'd5, 16'h03FF, "R1 entry 5");
        sw_read(7'd6, 16'h0155, "R1 entry 6");
        sw_read(7'd63, 16'h02AA, "R1 entry 63");

        // R2/R10/R4: queue 1 fetch of entry 6
        fetch_go(1'b0, 6'd6);
        want(SEL_FDATA, 16'h0155, 1, "R2 fetch entry 6");
        want(SEL_FPTR,  16'h0006, 1, "R10 fetch_ptr after fetch");
        want(SEL_ACT,   16'h0001, 1, "R10 q1 active");
        want(SEL_CWP1,  16'h003F, 1, "R4 fetch leaves cwp_q1");
        adv(); clr_strobes();

        // R4: results for each queue
        res_vld = 1'b1; res_q = 1'b0; res_idx = 6'd6;
        want(SEL_CWP1, 16'h0006, 1, "R4 q1 result");
        want(SEL_CWP2, 16'h003F, 1, "R4 q2 untouched");
        adv(); clr_strobes();
        res_vld = 1'b1; res_q = 1'b1; res_idx = 6'd41;
        want(SEL_CWP2, 16'h0029, 1, "R4 q2 result");
        want(SEL_CWP1, 16'h0006, 1, "R4 q1 untouched");
        adv(); clr_strobes();

        // R5: status layout
        sw_read(7'd64, 16'h0629, "R5 status layout");

        // R6: writes to read-only registers
        sw_write(7'd64, 16'hFFFF);
        sw_write(7'd65, 16'hFFFF);
        sw_read(7'd64, 16'h0629, "R6 status after write");
        sw_read(7'd65, 16'h0206, "R6 R11 activity after write");

        // R3: same-cycle write and fetch of entry 6
        sw_wr = 1'b1; sw_addr = 7'd6; sw_wdata = 16'h00AA;
        fetch_go(1'b0, 6'd6);
        want(SEL_FDATA, 16'h0155, 1, "R3 collision returns old");
        adv(); clr_strobes();
        fetch_go(1'b0, 6'd6);
        want(SEL_FDATA, 16'h00AA, 1, "R3 later fetch returns new");
        adv(); clr_strobes();

        // R7: queue 1 reaches queue 2 start entry
        fetch_go(1'b0, 6'd40);
        want(SEL_FPTR, 16'h0028, 1, "R7 fetch_ptr at q2 start");
        want(SEL_ACT,  16'h0000, 1, "R7 q1 ended");
        want(SEL_CWP1, 16'h0006, 1, "R7 cwp_q1 kept");
        adv(); clr_strobes();

        // R10: queue 2 runs then finishes
        fetch_go(1'b1, 6'd41);
        want(SEL_ACT, 16'h0002, 1, "R10 q2 active");
        adv(); clr_strobes();
        done_vld = 1'b1; done_q = 1'b1;
        want(SEL_ACT, 16'h0000, 1, "R10 q2 done");
        adv(); clr_strobes();
        fetch_go(1'b0, 6'd2);
        want(SEL_ACT,  16'h0001, 1, "R10 q1 active again");
        want(SEL_FPTR, 16'h0002, 1, "R10 fetch_ptr 2");
        adv(); clr_strobes();

        // R9: freeze with strobes arriving
        freeze = 1'b1;
        res_vld = 1'b1; res_q = 1'b0; res_idx = 6'd9;
        fetch_go(1'b1, 6'd12);
        want(SEL_CWP1, 16'h0006, 1, "R9 cwp_q1 held");
        want(SEL_ACT,  16'h0001, 1, "R9 activity held");
        want(SEL_FPTR, 16'h0002, 1, "R9 fetch_ptr held");
        adv(); clr_strobes();
        sw_read(7'd65, 16'h0202, "R11 activity during freeze");
        freeze = 1'b0;

        // R8: stop beats result write
        stop = 1'b1;
        res_vld = 1'b1; res_q = 1'b0; res_idx = 6'd9;
        want(SEL_CWP1, 16'h003F, 1, "R8 stop cwp_q1");
        want(SEL_CWP2, 16'h003F, 1, "R8 stop cwp_q2");
        want(SEL_ACT,  16'h0000, 1, "R8 stop activity");
        want(SEL_FPTR, 16'h0000, 1, "R8 stop fetch_ptr");
        adv(); clr_strobes();
        stop = 1'b0;
        sw_read(7'd64, 16'h3F3F, "R8 R5 status after stop");

        adv(); adv();
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule